// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sequences the two gate enables of a synchronous buck half-bridge from a single logic PWM level. It makes sure the two switches are never commanded on together. Instead of a fixed dead-time count, each turn-on waits for sensed proof that the opposite switch has really turned off. That proof arrives as two digitized comparator flags. The first says the switch node has fallen below its threshold, which is near 2 V. The second says the low-side gate voltage has dropped below its threshold, which is near 1 V.

When the inductor current is negative, the switch node does not fall after the high-side turn-off. For that case a watchdog lets the low side turn on after a fixed number of clock cycles, so the current can recirculate. A run enable from the surrounding mode controller forces both enables off and parks the sequencer in an idle state. The PWM level and both flags are synchronized through two flops before the state machine uses them. Both gate enables come straight from flops.

Top module: `deadtime_sequencer`

## Requirements
- R1: While reset is held, and after release with the run enable low, both gate enables are low.
- R2: The high-side and low-side enables are never both high in the same cycle.
- R3: A PWM fall drops the high-side enable on the third rising clock edge after the input changes (two synchronizer flops plus the output flop). The low-side enable stays low until the switch-node-low flag is seen high after synchronization. If the flag is already high, the low side turns on one cycle after the high side turns off.
- R4: A PWM rise drops the low-side enable on the third rising edge after the input changes. The high-side enable stays low for as long as the low-gate-low flag is low. Once that flag rises, the high side turns on on the third edge after the flag changes. If the flag is already high, the high side turns on one cycle after the low side turns off.
- R5: If the switch-node-low flag stays low, the low-side enable rises exactly WD_CYCLES clock cycles after the high-side enable falls. The default is 16.
- R6: If the switch-node-low flag rises before the watchdog expires, the low-side enable rises on the third edge after the flag input changes.
- R7: When the run enable is low at a clock edge, both enables are low after that edge and the sequencer goes idle. On the first edge with the run enable high, idle moves to the wait state that the synchronized PWM level selects. With the matching flag already high, the chosen enable rises on the second edge.
- R8: If the PWM level reverses while a turn-on is still waiting for its flag, that pending turn-on is abandoned. The sequencer then waits for the flag of the opposite switch, and both enables stay low in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable from the mode controller, same clock domain |
| pwm_in | input | 1 | PWM command level, asynchronous |
| sw_low_in | input | 1 | Switch node below its threshold, asynchronous |
| lg_low_in | input | 1 | Low-side gate below its threshold, asynchronous |
| hs_en | output | 1 | High-side gate enable, registered |
| ls_en | output | 1 | Low-side gate enable, registered |

## Verification
Two functions can both try to turn the low side on in the same cycle. One is the watchdog reaching its count. The other is the switch-node flag arriving late in the wait, or a PWM reversal pulling the sequencer out of that wait. The directed tests place the flag a few cycles into the wait and, separately, hold it low across the whole window, and compare the cycle of the low-side rise against the count worked out from the synchronizer depth and the timeout. A long random run toggles PWM, both flags and the run enable freely. At every cycle it checks that the two enables never overlap, that the high side only rises after a low-gate-low flag that was driven three edges earlier, and that a dropped run enable clears both outputs.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic [4:0] {
    ST_IDLE    = 5'b00001,
    ST_HS      = 5'b00010,
    ST_WAIT_SW = 5'b00100,
    ST_LS      = 5'b01000,
    ST_WAIT_LG = 5'b10000
  } seq_state_e;

  // Counter width needed to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dts_sync.sv
module dts_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dts_watchdog.sv
module dts_watchdog #(
  parameter int WD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);
  import dts_pkg::*;

  localparam int CW = cnt_width(WD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

  logic [CW-1:0] cnt;

  // Saturating step while armed, cleared when disarmed
  function automatic logic [CW-1:0] wd_step(input logic armed, input logic [CW-1:0] c);
    if (!armed)      return '0;
    else if (c == LAST) return c;
    else             return c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= wd_step(arm, cnt);
  end

  assign expire = arm && (cnt == LAST);

endmodule

// File: rtl/dts_fsm.sv
module dts_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic pwm_s,
  input  logic sw_low_s,
  input  logic lg_low_s,
  input  logic wd_expire,
  output logic wd_arm,
  output logic hs_en_o,
  output logic ls_en_o
);
  import dts_pkg::*;

  seq_state_e state, nxt;

  always_comb begin
    nxt = state;
    if (!run_en) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    nxt = pwm_s ? ST_WAIT_LG : ST_WAIT_SW;
        ST_HS:      if (!pwm_s) nxt = ST_WAIT_SW;
        ST_WAIT_SW: if (pwm_s) nxt = ST_WAIT_LG;
                    else if (sw_low_s || wd_expire) nxt = ST_LS;
        ST_LS:      if (pwm_s) nxt = ST_WAIT_LG;
        ST_WAIT_LG: if (!pwm_s) nxt = ST_WAIT_SW;
                    else if (lg_low_s) nxt = ST_HS;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hs_en_o <= 1'b0;
      ls_en_o <= 1'b0;
    end else begin
      state   <= nxt;
      hs_en_o <= (nxt == ST_HS);
      ls_en_o <= (nxt == ST_LS);
    end
  end

  assign wd_arm = (state == ST_WAIT_SW);

  // R2: shoot-through guard
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o));

  // R3: low side only turns on after switch node low or watchdog
  p_ls_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en_o) |-> $past(sw_low_s || wd_expire));

  // R3: high side drops the edge after a synchronized PWM fall
  p_hs_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en_o && run_en && !pwm_s) |=> !hs_en_o);

  // R4: high side only turns on after low gate is seen low
  p_hs_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> $past(lg_low_s));

  // R4: low side drops the edge after a synchronized PWM rise
  p_ls_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en_o && run_en && pwm_s) |=> !ls_en_o);

  // R7: run enable low clears both outputs
  p_run_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!hs_en_o && !ls_en_o));

endmodule

// File: rtl/deadtime_sequencer.sv
module deadtime_sequencer #(
  parameter int WD_CYCLES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic pwm_in,
  input  logic sw_low_in,
  input  logic lg_low_in,
  output logic hs_en,
  output logic ls_en
);

  logic [2:0] raw_in, synced;
  logic       pwm_s, sw_low_s, lg_low_s;
  logic       wd_arm, wd_expire;

  assign raw_in = {lg_low_in, sw_low_in, pwm_in};

  dts_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (synced)
  );

  assign pwm_s    = synced[0];
  assign sw_low_s = synced[1];
  assign lg_low_s = synced[2];

  dts_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (wd_arm),
    .expire (wd_expire)
  );

  dts_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .pwm_s     (pwm_s),
    .sw_low_s  (sw_low_s),
    .lg_low_s  (lg_low_s),
    .wd_expire (wd_expire),
    .wd_arm    (wd_arm),
    .hs_en_o   (hs_en),
    .ls_en_o   (ls_en)
  );

  // R5: watchdog only fires while waiting for the switch node
  p_wd_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) && !$past(sw_low_s) |-> $past(wd_expire));

  // R1: outputs low in the cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> (!hs_en && !ls_en));

endmodule

// File: tb/deadtime_sequencer_test.sv
`timescale 1ns/1ps
module deadtime_sequencer_test;

  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst_n, run_en, pwm_in, sw_low_in, lg_low_in;
  logic hs_en, ls_en;
  int tests = 0;
  int fails = 0;
  int cyc = 0;

  deadtime_sequencer #(.WD_CYCLES(WD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwm_in(pwm_in),
    .sw_low_in(sw_low_in), .lg_low_in(lg_low_in), .hs_en(hs_en), .ls_en(ls_en)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL R2 watchdog timeout actual=%0d cycles expected<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic eh, input logic el);
    tests++;
    if ({hs_en, ls_en} !== {eh, el}) begin
      fails++;
      $display("FAIL %s hs,ls actual=%b%b expected=%b%b (t=%0t)", tag, hs_en, ls_en, eh, el, $time);
    end
  endtask

  // Expected high-side rise legality: low-gate flag driven three edges earlier
  function automatic logic hs_rise_ok(input logic lg_three_back);
    return lg_three_back;
  endfunction

  initial begin
    logic lg_h0, lg_h1, lg_h2, ren_h0, hs_p;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run_en = 1'b0; pwm_in = 1'b1; sw_low_in = 1'b0; lg_low_in = 1'b1;
    step(3);
    expect_out("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(3);
    expect_out("R1 idle run low", 1'b0, 1'b0);

    // R7 enable with PWM high, R4 flag already low-gate
    run_en = 1'b1;
    step(1); expect_out("R7 first edge wait", 1'b0, 1'b0);
    step(1); expect_out("R7 hs second edge", 1'b1, 1'b0);

    // R3 PWM fall with switch node already low
    pwm_in = 1'b0; sw_low_in = 1'b1;
    step(2); expect_out("R3 hs held by sync", 1'b1, 1'b0);
    step(1); expect_out("R3 hs off third edge", 1'b0, 1'b0);
    step(1); expect_out("R3 ls on next cycle", 1'b0, 1'b1);

    // R4 PWM rise with low gate not yet low
    sw_low_in = 1'b0; lg_low_in = 1'b0; pwm_in = 1'b1;
    step(2); expect_out("R4 ls held by sync", 1'b0, 1'b1);
    step(1); expect_out("R4 ls off third edge", 1'b0, 1'b0);
    step(8); expect_out("R4 hs waits for flag", 1'b0, 1'b0);
    lg_low_in = 1'b1;
    step(2); expect_out("R4 hs flag in sync", 1'b0, 1'b0);
    step(1); expect_out("R4 hs on after flag", 1'b1, 1'b0);

    // R5 watchdog: switch node never falls
    pwm_in = 1'b0;
    step(3); expect_out("R5 hs off", 1'b0, 1'b0);
    step(WD - 1); expect_out("R5 before timeout", 1'b0, 1'b0);
    step(1); expect_out("R5 ls on at timeout", 1'b0, 1'b1);

    // R6 flag arrives mid-wait
    pwm_in = 1'b1;
    step(4); expect_out("R6 setup hs on", 1'b1, 1'b0);
    pwm_in = 1'b0;
    step(3); expect_out("R6 hs off", 1'b0, 1'b0);
    step(2); sw_low_in = 1'b1;
    step(2); expect_out("R6 flag in sync", 1'b0, 1'b0);
    step(1); expect_out("R6 ls on early", 1'b0, 1'b1);

    // R8 PWM reversal during a high-side wait
    lg_low_in = 1'b0; pwm_in = 1'b1;
    step(3); expect_out("R8 waiting low gate", 1'b0, 1'b0);
    step(2); pwm_in = 1'b0;
    step(3); expect_out("R8 reversed, both off", 1'b0, 1'b0);
    step(1); expect_out("R8 ls back on", 1'b0, 1'b1);

    // R7 run enable drop and restart with PWM low
    lg_low_in = 1'b1; pwm_in = 1'b1;
    step(4); expect_out("R7 setup hs on", 1'b1, 1'b0);
    run_en = 1'b0;
    step(1); expect_out("R7 forced off", 1'b0, 1'b0);
    pwm_in = 1'b0;
    step(3); expect_out("R7 stays idle", 1'b0, 1'b0);
    run_en = 1'b1;
    step(1); expect_out("R7 restart wait", 1'b0, 1'b0);
    step(1); expect_out("R7 restart ls on", 1'b0, 1'b1);

    // Random phase: R2, R4, R7 invariants
    lg_h0 = lg_low_in; lg_h1 = lg_low_in; lg_h2 = lg_low_in; ren_h0 = run_en; hs_p = hs_en;
    for (int i = 0; i < 4000; i++) begin
      step(1);
      tests++;
      if (hs_en && ls_en) begin
        fails++;
        $display("FAIL R2 overlap actual=%b%b expected=not 11", hs_en, ls_en);
      end
      if (hs_en && !hs_p) begin
        tests++;
        if (!hs_rise_ok(lg_h2)) begin
          fails++;
          $display("FAIL R4 hs rose without flag actual=%b expected=1", lg_h2);
        end
      end
      if (!ren_h0) begin
        tests++;
        if (hs_en || ls_en) begin
          fails++;
          $display("FAIL R7 run low actual=%b%b expected=00", hs_en, ls_en);
        end
      end
      hs_p = hs_en;
      if (($urandom % 8) == 0) pwm_in = ~pwm_in;
      if (($urandom % 4) == 0) sw_low_in = ~sw_low_in;
      if (($urandom % 4) == 0) lg_low_in = ~lg_low_in;
      run_en = (($urandom % 50) != 0);
      lg_h2 = lg_h1; lg_h1 = lg_h0; lg_h0 = lg_low_in; ren_h0 = run_en;
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule